// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block sits beside a small microcontroller core and decides which oscillator paces it and when it is allowed to run. It runs on one free-running fabric clock and sees each oscillator as a one-cycle tick input, so it never has to form a clock itself. One tick input comes from the fast main oscillator and one from the 32.768 kHz sub-oscillator. From these ticks it produces a core clock enable, a machine-cycle strobe on every fourth core pulse, and a sub-clock enable for the timers that keep counting during light sleep.

Software picks the clock source and turns the main oscillator on or off through a two-bit configuration write. A change of source is glitch-free. The old source is drained on its next tick, one tick of the new source is spent to arm it, and only then do core pulses resume.

There are two sleep depths. In hold, the core is gated while the sub-clock keeps running, and any enabled pending interrupt ends it. In stop, both oscillators are treated as halted and interrupts are ignored. Stop ends only when a wake-up pin whose mask bit is set changes level. The core then stays gated for a programmable number of source ticks while the oscillator settles.

Top module: `pwrclk_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, every register is cleared. After that edge core_ce, cyc_stb, sub_ce, cur_sel_sub, osc_refused, in_hold, in_stop and in_settle are 0 and main_on is 1, so the main clock is selected and running.
- R2: With the main clock selected, no switch pending and the block running, core_ce is high exactly in the cycle after each cycle where main_tick is high.
- R3: cyc_stb is high only together with core_ce, on the 4th, 8th, 12th and later core_ce pulses counted from reset. The count is kept through hold and stop.
- R4: A configuration write with a different cfg_sel_sub starts a switch. From the cycle after the write until cur_sel_sub changes, core_ce stays low, and core_ce is also low in the cycle where cur_sel_sub changes. Afterwards core_ce follows the new source's tick with one cycle of latency.
- R5: A write with cfg_main_en = 0 is accepted only when cfg_sel_sub = 1 and the sub-clock is already both the requested and the active source. In that case main_on becomes 0 and osc_refused becomes 0. Otherwise main_on stays 1 and osc_refused becomes 1. Any accepted write clears osc_refused.
- R6: A hold_req pulse while running enters hold (in_hold = 1). During hold core_ce is low and sub_ce keeps following sub_tick. Hold ends at the first cycle where irq_pend & irq_en is nonzero, and pending interrupts whose enable bit is 0 are ignored.
- R7: A stop_req pulse while running enters stop (in_stop = 1), and stop wins when hold_req is asserted in the same cycle. During stop core_ce and sub_ce are low and interrupts are ignored. A change on a wake pin whose wake_mask bit is 0 is ignored. A change on a pin whose mask bit is 1 moves the block to settle.
- R8: In settle (in_settle = 1), core_ce stays low while the selected source delivers settle_cycles ticks. The block then runs again, and core_ce first rises one cycle after tick number settle_cycles+1. A value of 0 resumes on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running fabric clock |
| rst_n | input | 1 | Synchronous reset, active low |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per sub-oscillator period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_sub | input | 1 | Requested source: 1 sub-clock, 0 main clock |
| cfg_main_en | input | 1 | Requested main oscillator enable |
| hold_req | input | 1 | Enter hold |
| stop_req | input | 1 | Enter stop (priority over hold) |
| irq_pend | input | IRQ_W | Pending interrupt requests |
| irq_en | input | IRQ_W | Interrupt enables |
| wake_pins | input | WAKE_W | Wake-up port pin levels |
| wake_mask | input | WAKE_W | Per-pin wake enable |
| settle_cycles | input | SETTLE_W | Source ticks to wait after stop |
| core_ce | output | 1 | Gated core clock enable |
| cyc_stb | output | 1 | Machine-cycle strobe |
| sub_ce | output | 1 | Sub-clock enable for timers |
| cur_sel_sub | output | 1 | Active source is the sub-clock |
| main_on | output | 1 | Main oscillator enabled |
| osc_refused | output | 1 | Last oscillator-off request was refused |
| in_hold | output | 1 | Hold state |
| in_stop | output | 1 | Stop state |
| in_settle | output | 1 | Settling after stop |

## Verification
The case that is hardest to reach from the ports is resuming from stop. The settle count has to be reached before the core restarts, and the bench has to know exactly which source tick is the first one let through. The bench enters stop with interrupts pending and enabled, and toggles a masked-off pin first to show that stop holds. It then toggles an enabled pin just after a sub tick so that no tick lands on a state change. It counts sub ticks from there and expects the first core pulse on tick settle_cycles+1, using a random count and also a count of zero. Hold exits are checked with random interrupt and enable patterns against a bench model.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;
  typedef enum logic [1:0] {PS_RUN, PS_HOLD, PS_STOP, PS_SETTLE} pstate_t;
  typedef enum logic [1:0] {SW_IDLE, SW_DRAIN, SW_ARM} swstate_t;
endpackage

// File: rtl/pwrclk_switch.sv
module pwrclk_switch
  import pwrclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic main_tick,
  input  logic sub_tick,
  input  logic halt,
  input  logic cfg_we,
  input  logic cfg_sel_sub,
  input  logic cfg_main_en,
  output logic sys_tick,
  output logic sel_act,
  output logic main_on,
  output logic refused
);
  logic     sel_tgt;
  swstate_t sw;
  logic     raw_main, raw_sub, old_raw, new_raw, allow_off;

  assign raw_main  = main_tick & main_on & ~halt;
  assign raw_sub   = sub_tick & ~halt;
  assign old_raw   = sel_act ? raw_sub : raw_main;
  assign new_raw   = sel_tgt ? raw_sub : raw_main;
  assign sys_tick  = (sw == SW_IDLE) && (sel_tgt == sel_act) && old_raw;
  assign allow_off = cfg_sel_sub & sel_act & sel_tgt & (sw == SW_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_tgt <= 1'b0;
      sel_act <= 1'b0;
      main_on <= 1'b1;
      refused <= 1'b0;
      sw      <= SW_IDLE;
    end else begin
      if (cfg_we) begin
        sel_tgt <= cfg_sel_sub;
        if (!cfg_main_en && !allow_off) begin
          main_on <= 1'b1;
          refused <= 1'b1;
        end else begin
          main_on <= cfg_main_en;
          refused <= 1'b0;
        end
      end
      case (sw)
        SW_IDLE:  if (sel_tgt != sel_act) sw <= SW_DRAIN;
        SW_DRAIN: if (sel_tgt == sel_act) sw <= SW_IDLE;
                  else if (old_raw) sw <= SW_ARM;
        SW_ARM:   if (new_raw) begin
                    sel_act <= sel_tgt;
                    sw      <= SW_IDLE;
                  end
        default:  sw <= SW_IDLE;
      endcase
    end
  end

  // R5: a main-clock target or active selection always has the oscillator on
  p_main_needs_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_act || !sel_tgt) |-> main_on);
  // R5: a refusal never leaves the oscillator off
  p_refused_keeps_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refused) |-> main_on);
endmodule

// File: rtl/pwrclk_fsm.sv
module pwrclk_fsm
  import pwrclk_pkg::*;
#(
  parameter int IRQ_W    = 8,
  parameter int WAKE_W   = 8,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_req,
  input  logic                stop_req,
  input  logic [IRQ_W-1:0]    irq_pend,
  input  logic [IRQ_W-1:0]    irq_en,
  input  logic [WAKE_W-1:0]   wake_pins,
  input  logic [WAKE_W-1:0]   wake_mask,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                sys_tick,
  output pstate_t             pstate
);
  logic [WAKE_W-1:0]   pins_q;
  logic [SETTLE_W-1:0] cnt;
  logic                wake_edge, irq_hit;

  assign wake_edge = |((wake_pins ^ pins_q) & wake_mask);
  assign irq_hit   = |(irq_pend & irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate <= PS_RUN;
      pins_q <= '0;
      cnt    <= '0;
    end else begin
      pins_q <= wake_pins;
      case (pstate)
        PS_RUN:    if (stop_req) pstate <= PS_STOP;
                   else if (hold_req) pstate <= PS_HOLD;
        PS_HOLD:   if (irq_hit) pstate <= PS_RUN;
        PS_STOP:   if (wake_edge) begin
                     pstate <= PS_SETTLE;
                     cnt    <= settle_cycles;
                   end
        PS_SETTLE: if (cnt == '0) pstate <= PS_RUN;
                   else if (sys_tick) cnt <= cnt - 1'b1;
        default:   pstate <= PS_RUN;
      endcase
    end
  end

  // R6: an enabled pending interrupt ends hold on the next edge
  p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_HOLD && irq_hit) |=> pstate == PS_RUN);
  // R7: without a masked pin change stop persists
  p_stop_persists_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_STOP && !wake_edge) |=> pstate == PS_STOP);
endmodule

// File: rtl/pwrclk_cycdiv.sv
module pwrclk_cycdiv #(
  parameter int CYC_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic core_ce,
  output logic cyc_stb
);
  localparam int PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      core_ce <= 1'b0;
      cyc_stb <= 1'b0;
    end else begin
      core_ce <= tick_in;
      cyc_stb <= tick_in && (ph == LAST);
      if (tick_in) ph <= (ph == LAST) ? '0 : ph + 1'b1;
    end
  end

  // R3: the machine-cycle strobe only accompanies a core pulse
  p_stb_with_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |-> core_ce);
endmodule

// File: rtl/pwrclk_ctrl.sv
module pwrclk_ctrl
  import pwrclk_pkg::*;
#(
  parameter int IRQ_W    = 8,
  parameter int WAKE_W   = 8,
  parameter int SETTLE_W = 8,
  parameter int CYC_LEN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                main_tick,
  input  logic                sub_tick,
  input  logic                cfg_we,
  input  logic                cfg_sel_sub,
  input  logic                cfg_main_en,
  input  logic                hold_req,
  input  logic                stop_req,
  input  logic [IRQ_W-1:0]    irq_pend,
  input  logic [IRQ_W-1:0]    irq_en,
  input  logic [WAKE_W-1:0]   wake_pins,
  input  logic [WAKE_W-1:0]   wake_mask,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                core_ce,
  output logic                cyc_stb,
  output logic                sub_ce,
  output logic                cur_sel_sub,
  output logic                main_on,
  output logic                osc_refused,
  output logic                in_hold,
  output logic                in_stop,
  output logic                in_settle
);
  pstate_t pstate;
  logic    sys_tick, halt;

  assign halt      = (pstate == PS_STOP);
  assign in_hold   = (pstate == PS_HOLD);
  assign in_stop   = halt;
  assign in_settle = (pstate == PS_SETTLE);

  pwrclk_switch u_switch (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .halt(halt), .cfg_we(cfg_we), .cfg_sel_sub(cfg_sel_sub),
    .cfg_main_en(cfg_main_en), .sys_tick(sys_tick), .sel_act(cur_sel_sub),
    .main_on(main_on), .refused(osc_refused)
  );

  pwrclk_fsm #(.IRQ_W(IRQ_W), .WAKE_W(WAKE_W), .SETTLE_W(SETTLE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .wake_pins(wake_pins),
    .wake_mask(wake_mask), .settle_cycles(settle_cycles),
    .sys_tick(sys_tick), .pstate(pstate)
  );

  pwrclk_cycdiv #(.CYC_LEN(CYC_LEN)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(sys_tick && (pstate == PS_RUN)),
    .core_ce(core_ce), .cyc_stb(cyc_stb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sub_ce <= 1'b0;
    else        sub_ce <= sub_tick && !halt;
  end

  // R6: the core is gated for every cycle spent in hold
  p_no_core_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_hold) |-> !core_ce);
  // R7: the sub-clock enable is silent during stop
  p_sub_quiet_in_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_stop) |-> !sub_ce);
  // R4: no core pulse on the edge where the source changes
  p_switch_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_sel_sub) |-> !core_ce);
endmodule

// File: tb/pwrclk_ctrl_tb.sv
module pwrclk_ctrl_tb;
  localparam int IRQ_W = 8, WAKE_W = 8, SETTLE_W = 8;
  localparam int MAIN_P = 3, SUB_P = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic main_tick = 1'b0, sub_tick = 1'b0;
  logic cfg_we = 1'b0, cfg_sel_sub = 1'b0, cfg_main_en = 1'b1;
  logic hold_req = 1'b0, stop_req = 1'b0;
  logic [IRQ_W-1:0] irq_pend = '0, irq_en = '0;
  logic [WAKE_W-1:0] wake_pins = '0, wake_mask = '0;
  logic [SETTLE_W-1:0] settle_cycles = '0;
  logic core_ce, cyc_stb, sub_ce, cur_sel_sub, main_on, osc_refused;
  logic in_hold, in_stop, in_settle;

  int tests = 0, fails = 0, ce_count = 0, mc = 0, sc = 0;
  bit done = 1'b0;

  pwrclk_ctrl #(.IRQ_W(IRQ_W), .WAKE_W(WAKE_W), .SETTLE_W(SETTLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .cfg_we(cfg_we), .cfg_sel_sub(cfg_sel_sub), .cfg_main_en(cfg_main_en),
    .hold_req(hold_req), .stop_req(stop_req), .irq_pend(irq_pend),
    .irq_en(irq_en), .wake_pins(wake_pins), .wake_mask(wake_mask),
    .settle_cycles(settle_cycles), .core_ce(core_ce), .cyc_stb(cyc_stb),
    .sub_ce(sub_ce), .cur_sel_sub(cur_sel_sub), .main_on(main_on),
    .osc_refused(osc_refused), .in_hold(in_hold), .in_stop(in_stop),
    .in_settle(in_settle)
  );

  always #10 clk = ~clk;

  // oscillator tick generators, driven away from the active edge
  always @(negedge clk) begin
    mc <= (mc == MAIN_P - 1) ? 0 : mc + 1;
    sc <= (sc == SUB_P - 1) ? 0 : sc + 1;
    main_tick <= (mc == 0);
    sub_tick  <= (sc == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // wait to the sampling point after the next rising edge
  task automatic step();
    @(posedge clk); #2;
  endtask

  // R3 monitor: strobe on every 4th core pulse since reset
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (core_ce) ce_count++;
      if (cyc_stb || core_ce)
        chk(cyc_stb == (core_ce && (ce_count % 4 == 0)), "R3 strobe",
            int'(cyc_stb), int'(core_ce && (ce_count % 4 == 0)));
    end
  end

  task automatic cfg_write(input bit sel, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_sub = sel; cfg_main_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic track(input bit use_sub, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step();
      chk(core_ce == (use_sub ? sub_tick : main_tick), tag,
          int'(core_ce), int'(use_sub ? sub_tick : main_tick));
    end
  endtask

  task automatic do_switch(input bit to_sub);
    int guard = 0;
    bit quiet = 1'b1;
    cfg_write(to_sub, 1'b1);
    // the sample at this negedge follows the write edge; check from the next
    while (cur_sel_sub != to_sub && guard < 200) begin
      step();
      if (core_ce) quiet = 1'b0;
      guard++;
    end
    chk(cur_sel_sub == to_sub, "R4 switch completes", int'(cur_sel_sub), int'(to_sub));
    chk(quiet, "R4 no core pulse while switching", int'(!quiet), 0);
    track(to_sub, 40, "R4 follows new source");
  endtask

  task automatic settle_run(input int n);
    int k = 0, first = -1;
    settle_cycles = SETTLE_W'(n);
    while (!sub_tick) step();
    @(negedge clk);
    wake_pins[0] = ~wake_pins[0];
    step();
    chk(in_settle == 1'b1, "R7 masked pin leaves stop", int'(in_settle), 1);
    for (int i = 0; i < 200 && first < 0; i++) begin
      step();
      if (sub_tick) k++;
      if (core_ce) first = k;
    end
    chk(first == n + 1, "R8 first core pulse after settle ticks", first, n + 1);
  endtask

  task automatic enter_stop();
    @(negedge clk);
    stop_req = 1'b1; hold_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0; hold_req = 1'b0;
    #12;
    chk(in_stop && !in_hold, "R7 stop wins over hold", int'(in_stop), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    wake_mask = 8'h01;
    repeat (4) @(negedge clk);
    #12;
    // R1
    chk(core_ce == 0 && cyc_stb == 0 && sub_ce == 0, "R1 outputs low", int'(core_ce), 0);
    chk(cur_sel_sub == 0 && main_on == 1, "R1 main selected and on", int'(cur_sel_sub), 0);
    chk(!osc_refused && !in_hold && !in_stop && !in_settle, "R1 state idle",
        int'(osc_refused), 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    track(1'b0, 60, "R2 core follows main tick");

    // R5 refusal while main selected
    cfg_write(1'b0, 1'b0);
    #2;
    chk(osc_refused == 1'b1, "R5 refusal flagged", int'(osc_refused), 1);
    chk(main_on == 1'b1, "R5 main stays on", int'(main_on), 1);
    track(1'b0, 20, "R5 core unaffected by refusal");

    do_switch(1'b1);
    chk(osc_refused == 1'b0, "R5 accepted write clears flag", int'(osc_refused), 0);
    cfg_write(1'b1, 1'b0);
    #2;
    chk(main_on == 1'b0 && osc_refused == 1'b0, "R5 main off on sub", int'(main_on), 0);
    track(1'b1, 30, "R4 sub source after main off");

    // R6 hold with disabled interrupts pending
    @(negedge clk); hold_req = 1'b1; irq_pend = 8'hA5; irq_en = 8'h5A;
    @(negedge clk); hold_req = 1'b0;
    #12;
    chk(in_hold == 1'b1, "R6 hold entered", int'(in_hold), 1);
    for (int i = 0; i < 30; i++) begin
      step();
      chk(in_hold && !core_ce, "R6 disabled irq ignored, core gated", int'(core_ce), 0);
      chk(sub_ce == sub_tick, "R6 sub clock runs in hold", int'(sub_ce), int'(sub_tick));
    end
    // random hold episodes against a bench model
    for (int ep = 0; ep < 6; ep++) begin
      bit exp_h;
      @(negedge clk); irq_pend = '0; hold_req = !in_hold;
      @(negedge clk); hold_req = 1'b0;
      exp_h = 1'b1;
      for (int i = 0; i < 40; i++) begin
        irq_pend = IRQ_W'($urandom_range(0, 255)) & IRQ_W'($urandom_range(0, 255))
                   & IRQ_W'($urandom_range(0, 255));
        irq_en   = IRQ_W'($urandom_range(0, 255)) & IRQ_W'($urandom_range(0, 255));
        step();
        if (exp_h && ((irq_pend & irq_en) != '0)) exp_h = 1'b0;
        chk(in_hold == exp_h, "R6 hold exit on enabled irq", int'(in_hold), int'(exp_h));
        @(negedge clk);
        if (!exp_h) break;
      end
      irq_pend = '0;
      if (in_hold) begin irq_pend = 8'h01; irq_en = 8'h01; @(negedge clk); irq_pend = '0; end
    end
    track(1'b1, 20, "R6 core resumes after hold");

    // R7 / R8 stop and settle
    irq_en = 8'hFF;
    enter_stop();
    irq_pend = 8'hFF;
    for (int i = 0; i < 30; i++) begin
      step();
      chk(in_stop && !core_ce && !sub_ce, "R7 all gated, irq ignored", int'(sub_ce), 0);
    end
    irq_pend = '0;
    @(negedge clk); wake_pins[5] = 1'b1;
    step(); step();
    chk(in_stop == 1'b1, "R7 unmasked-off pin ignored", int'(in_stop), 1);
    settle_run(int'($urandom_range(1, 6)));
    enter_stop();
    settle_run(0);

    do_switch(1'b0);
    chk(main_on == 1'b1, "R5 main on when selected", int'(main_on), 1);
    track(1'b0, 30, "R2 main again");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule